// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Cell

This cell stores a 64-entry truth table and computes any Boolean function of six select inputs. The six inputs drive a multiplexer tree, and the tree picks one stored bit as the result. The six selects taken as a binary number are the table index, with `sel[5]` as the most significant bit. The cell is built from two 32-entry halves. The lower half holds table bits 0 to 31 and the upper half holds bits 32 to 63. `sel[5]` picks which half drives the wide output.

A split mode gives two results at once. `y6` shows the upper half and `y5` shows the lower half, and both use `sel[4:0]`. In split mode `sel[5]` must be held high. The table can be rewritten while the cell runs, through a clocked load port. It accepts either a whole 64-bit word in one cycle or one bit per cycle shifted in. The outputs are purely combinational from the selects and the stored table.

The load port works as a small operation decoder with three operations, chosen again on every clock edge:
- **HOLD**: `cfg_en` is low, so the table keeps its contents.
- **WRITE**: `cfg_en` is high and `cfg_wide` is high, so the table takes `cfg_word`.
- **SHIFT**: `cfg_en` is high and `cfg_wide` is low, so the table shifts left by one and `cfg_ser` enters bit 0.

The decoder moves to any of the three operations on any edge, according to these inputs. It keeps no history between cycles.

Top module: `frac_lut6`

## Requirements
- R1: After reset all 64 table bits are 0, so `y6` and `y5` are 0 for every select value.
- R2: Outside split mode, `y6` equals table bit number `sel`, where `sel` read as an unsigned number is the index. This means any 64-bit pattern realises any truth table of the six inputs.
- R3: `sel[5]=1` selects an entry among table bits 32 to 63 (upper half), and `sel[5]=0` selects an entry among bits 0 to 31 (lower half). Within the chosen half, `sel[4:0]` is the index.
- R4: On a rising edge with `cfg_en=1` and `cfg_wide=1`, the table becomes `cfg_word`, with bit i of the word going to table entry i.
- R5: On a rising edge with `cfg_en=1` and `cfg_wide=0`, the table shifts one place toward higher indices and `cfg_ser` enters entry 0. After 64 such edges, the bit shifted in first sits at entry 63.
- R6: With `cfg_en=0`, changes on `cfg_word` and `cfg_ser` have no effect on the table or on the outputs.
- R7: A load changes the outputs only after its clock edge. In the cycle where the load is requested, the outputs still follow the old table.
- R8: With `split_mode=1`, `y5` equals lower-half entry `sel[4:0]`.
- R9: With `split_mode=0`, `y5` is held at 0.
- R10: When `cfg_en=1` and `cfg_wide=1`, the parallel word is taken and `cfg_ser` is ignored.
- R11: In split mode `sel[5]` must be 1, and `y6` then equals upper-half entry `sel[4:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for table loads |
| rst_n | input | 1 | Active-low synchronous reset, clears the table |
| cfg_en | input | 1 | Enables a table load on this edge |
| cfg_wide | input | 1 | 1: parallel word load, 0: serial shift |
| cfg_ser | input | 1 | Serial bit entering entry 0 |
| cfg_word | input | 64 | Parallel table word |
| split_mode | input | 1 | 1: two five-input outputs |
| sel | input | 6 | Function inputs and table index |
| y6 | output | 1 | Six-input result, or upper half in split mode |
| y5 | output | 1 | Lower-half result in split mode, else 0 |

## Verification
A table load and an evaluation can happen in the same cycle. The bench provokes this by driving a load request and a new select value together, then comparing the outputs half a period before the loading edge against the old table. It compares them again after the edge against the new table. Serial loads are judged the same way. The bench also provokes parallel and serial requests together, and changes load data while loading is disabled.

// File: rtl/flut_pkg.sv
package flut_pkg;
    localparam int HALF_IN_DEF = 5;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_WRITE = 2'd2
    } cfg_op_e;
endpackage

// File: rtl/flut_cfg_store.sv
module flut_cfg_store
    import flut_pkg::*;
#(
    parameter int NBITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_wide,
    input  logic             cfg_ser,
    input  logic [NBITS-1:0] cfg_word,
    output logic [NBITS-1:0] tbl_q
);
    cfg_op_e op;

    always_comb begin
        if (!cfg_en)       op = OP_HOLD;
        else if (cfg_wide) op = OP_WRITE;
        else               op = OP_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            unique case (op)
                OP_HOLD:  tbl_q <= tbl_q;
                OP_SHIFT: tbl_q <= {tbl_q[NBITS-2:0], cfg_ser};
                OP_WRITE: tbl_q <= cfg_word;
                default:  tbl_q <= tbl_q;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> tbl_q == '0);

    // R4
    word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_wide) |=> tbl_q == $past(cfg_word));

    // R5
    shift_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_wide) |=>
            tbl_q == {$past(tbl_q[NBITS-2:0]), $past(cfg_ser)});

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cfg_en) |=> $stable(tbl_q));
endmodule

// File: rtl/flut_half.sv
module flut_half #(
    parameter int HALF_IN = 5
) (
    input  logic [(1<<HALF_IN)-1:0] tbl,
    input  logic [HALF_IN-1:0]      sel,
    output logic                    y
);
    localparam int NB = 1 << HALF_IN;

    for (genvar l = 0; l < HALF_IN; l++) begin : g_stage
        localparam int W = NB >> (l + 1);
        logic [W-1:0] nodes;
        if (l == 0) begin : g_first
            for (genvar j = 0; j < W; j++) begin : g_node
                assign nodes[j] = sel[l] ? tbl[2*j+1] : tbl[2*j];
            end
        end else begin : g_rest
            for (genvar j = 0; j < W; j++) begin : g_node
                assign nodes[j] = sel[l] ? g_stage[l-1].nodes[2*j+1]
                                         : g_stage[l-1].nodes[2*j];
            end
        end
    end

    assign y = g_stage[HALF_IN-1].nodes[0];
endmodule

// File: rtl/frac_lut6.sv
module frac_lut6
    import flut_pkg::*;
#(
    parameter int HALF_IN = HALF_IN_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_en,
    input  logic                         cfg_wide,
    input  logic                         cfg_ser,
    input  logic [(2<<HALF_IN)-1:0]      cfg_word,
    input  logic                         split_mode,
    input  logic [HALF_IN:0]             sel,
    output logic                         y6,
    output logic                         y5
);
    localparam int HB = 1 << HALF_IN;
    localparam int NB = 2 * HB;

    logic [NB-1:0] tbl_q;
    logic          lo_y, hi_y;

    flut_cfg_store #(.NBITS(NB)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_wide (cfg_wide),
        .cfg_ser  (cfg_ser),
        .cfg_word (cfg_word),
        .tbl_q    (tbl_q)
    );

    flut_half #(.HALF_IN(HALF_IN)) u_lo (
        .tbl (tbl_q[HB-1:0]),
        .sel (sel[HALF_IN-1:0]),
        .y   (lo_y)
    );

    flut_half #(.HALF_IN(HALF_IN)) u_hi (
        .tbl (tbl_q[NB-1:HB]),
        .sel (sel[HALF_IN-1:0]),
        .y   (hi_y)
    );

    always_comb begin
        y6 = sel[HALF_IN] ? hi_y : lo_y;
        y5 = split_mode ? lo_y : 1'b0;
    end

    // R2
    wide_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y6 == tbl_q[sel]);

    // R8
    split_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_mode |-> y5 == tbl_q[{1'b0, sel[HALF_IN-1:0]}]);

    // R9
    single_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !split_mode |-> !y5);

    // R11
    split_sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_mode |-> sel[HALF_IN]);
endmodule

// File: tb/frac_lut6_bench.sv
`timescale 1ns/100ps
module frac_lut6_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_wide = 1'b0, cfg_ser = 1'b0;
    logic [63:0] cfg_word = '0;
    logic        split_mode = 1'b0;
    logic [5:0]  sel = '0;
    logic        y6, y5;

    always #2.5 clk = ~clk;

    frac_lut6 u_frac_lut6 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wide(cfg_wide),
        .cfg_ser(cfg_ser), .cfg_word(cfg_word), .split_mode(split_mode),
        .sel(sel), .y6(y6), .y5(y5)
    );

    typedef struct {
        logic  e6;
        logic  e5;
        string tag;
    } exp_t;

    exp_t        q[$];
    logic [63:0] model = '0;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;

    function automatic exp_t predict(input logic [5:0] s, input string tag);
        exp_t it;
        it.e6 = model[s];
        it.e5 = split_mode ? model[{1'b0, s[4:0]}] : 1'b0;
        it.tag = tag;
        return it;
    endfunction

    task automatic probe(input logic [5:0] s, input string tag);
        @(negedge clk);
        sel = s;
        q.push_back(predict(s, tag));
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 64; k++) probe(6'(k), tag);
    endtask

    task automatic load_word(input logic [63:0] w, input logic s_bit);
        @(negedge clk);
        cfg_en = 1'b1; cfg_wide = 1'b1; cfg_word = w; cfg_ser = s_bit;
        sel = 6'h2a;
        // R7: before the loading edge the old table is still seen
        q.push_back(predict(sel, "R7 load-cycle old table"));
        @(negedge clk);
        cfg_en = 1'b0;
        model = w;
        q.push_back(predict(sel, "R7 new table after edge"));
    endtask

    task automatic shift_word(input logic [63:0] w);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (i > 0) model = {model[62:0], w[64-i]};
            cfg_en = 1'b1; cfg_wide = 1'b0; cfg_ser = w[63-i];
            sel = 6'(i);
            q.push_back(predict(sel, "R5 shift in progress"));
        end
        @(negedge clk);
        model = {model[62:0], w[0]};
        cfg_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                it = q.pop_front();
                n_cmp++;
                if (y6 !== it.e6 || y5 !== it.e5) begin
                    n_bad++;
                    $display("FAIL %s sel=%h: actual y6=%b y5=%b expected y6=%b y5=%b",
                             it.tag, sel, y6, y5, it.e6, it.e5);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        for (int k = 0; k < 64; k += 9) probe(6'(k), "R1 reset table zero");
        // R4 / R2 / R3: distinct halves make the sixth input visible
        load_word(64'hFFFF_FFFF_0000_0000, 1'b0);
        probe(6'h20, "R3 upper half"); probe(6'h1f, "R3 lower half");
        // R2: six-input AND
        load_word(64'h8000_0000_0000_0000, 1'b0);
        sweep("R2 and6");
        // R2: parity
        load_word(64'h6996_9669_9669_6996, 1'b1);
        sweep("R2 parity");
        // R10: parallel beats serial (serial bit 1 would set entry 0)
        load_word(64'h1234_5678_9ABC_DEF0, 1'b1);
        probe(6'h00, "R10 parallel wins");
        sweep("R4 word load");
        // R6: disabled loads leave table alone
        @(negedge clk);
        cfg_wide = 1'b1; cfg_word = ~model; cfg_ser = 1'b1;
        repeat (3) @(negedge clk);
        cfg_wide = 1'b0; cfg_word = '0;
        repeat (3) @(negedge clk);
        sweep("R6 hold while disabled");
        // R5 serial ordering
        shift_word(64'hC3A5_0F1E_7D24_B869);
        sweep("R5 serial result");
        // R8 / R11 split mode, sel[5] raised with the mode
        @(negedge clk);
        sel = 6'h20; split_mode = 1'b1;
        for (int k = 0; k < 32; k++) probe({1'b1, 5'(k)}, "R8 R11 split outputs");
        load_word(64'h0F0F_F0F0_AAAA_5555, 1'b0);
        for (int k = 0; k < 32; k++) probe({1'b1, 5'(k)}, "R8 R11 split after reload");
        @(negedge clk);
        split_mode = 1'b0;
        // R9
        for (int k = 0; k < 64; k += 5) probe(6'(k), "R9 single mode y5 low");
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule